// File: doc/BRIEF.md
# Triggered Frequency List Sequencer

This block walks a list of frequency points and tells downstream tuning logic which point to tune to. Each time it presents a new point it drives the point index and raises a strobe for one cycle. The list itself, the frequency arithmetic and the RF control sit elsewhere. Only the position in the list and its timing are handled here.

The sequence begins on a trigger. The trigger can come from a software pulse or from an asynchronous pin; in the pin case only a falling edge counts. Two trigger modes are available:
- **Start/stop mode.** One trigger starts the list. The list then steps by itself, holding each point for a programmed number of clock ticks, until another trigger stops it or the programmed number of cycles completes.
- **Step-on-trigger mode.** Each trigger moves the list by exactly one point.

The list can run upward or downward. At the far end it either wraps back to the first point or bounces back toward it, which traces a triangle of frequency against time.

Top module: `freq_list_seq`

## Requirements
- R1: With `cfgHwTrig`=1 the trigger is a high-to-low transition of `trigPin`, taken through a two-flop synchronizer. The action shows on the outputs after the third rising clock edge that follows the falling pin level. A rising edge has no effect and `swTrig` is ignored. With `cfgHwTrig`=0 the trigger is `swTrig` high at a clock edge, and `trigPin` is ignored.
- R2: In start/stop mode (`cfgStepMode`=0), a trigger while idle starts the list at its first point. The first point is index 0 when `cfgDirDown`=0 and index `cfgNumPoints`-1 when `cfgDirDown`=1. `listRunning` goes to 1 in the same cycle as the first strobe.
- R3: In start/stop mode each point is held for `cfgDwell` clock cycles before the next one is presented. A `cfgDwell` of 0 behaves as 1.
- R4: In start/stop mode, a trigger while running stops the list. After the stop, `listRunning`=0, `listDone`=0, `pointIdx` holds, and no further strobes appear.
- R5: In step-on-trigger mode (`cfgStepMode`=1), a trigger while idle starts the list and each later trigger advances it by exactly one point. The dwell time never advances it.
- R6: In wrap mode (`cfgBounce`=0) the index steps by one away from the first point. After the last point it returns to the first point, which completes one cycle.
- R7: In bounce mode (`cfgBounce`=1) the index runs from the first point to the last point and then reverses. A cycle completes when it gets back to the first point, and the next cycle continues from the neighbour of the first point. For 4 points going up, two cycles read 0,1,2,3,2,1,0,1,2,3,2,1,0.
- R8: After `cfgCycles` complete cycles the list ends. At that point `listRunning`=0, `listDone`=1, no strobe is issued, and `pointIdx` holds the last presented point. `listDone` clears at the next start. A `cfgCycles` of 0 repeats without end.
- R9: `pointStrobe` is high for exactly one cycle each time a point is presented, including the first point. With a one-point list, every presentation of index 0 gives a strobe.
- R10: With `cfgNumPoints`=0, triggers are ignored and the list stays idle.
- R11: After reset `pointIdx`=0, `pointStrobe`=0, `listRunning`=0 and `listDone`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgNumPoints | input | 24 | Number of list points |
| cfgDwell | input | 32 | Hold time per point in clock cycles |
| cfgCycles | input | 16 | Number of cycles, 0 for endless |
| cfgDirDown | input | 1 | 1 runs from the top index downward |
| cfgBounce | input | 1 | 1 selects bounce, 0 selects wrap |
| cfgHwTrig | input | 1 | 1 selects the pin trigger, 0 selects the software trigger |
| cfgStepMode | input | 1 | 1 selects step-on-trigger, 0 selects start/stop |
| trigPin | input | 1 | Asynchronous trigger pin, active on a falling edge |
| swTrig | input | 1 | Software trigger pulse |
| pointIdx | output | 24 | Current point index |
| pointStrobe | output | 1 | One-cycle new-point strobe |
| listRunning | output | 1 | List is running |
| listDone | output | 1 | List ended after its cycle count |

## Verification
The sequencing is driven in several configurations:
- An upward wrap over two cycles, which separates correct wrap order from off-by-one end detection and also confirms the dwell spacing.
- A downward bounce with zero dwell and an upward bounce over two cycles, which separate the reversal point from the cycle boundary.
- A one-point list, which shows the strobe repeating on an index that does not change.

Trigger handling is checked separately:
- An endless run stopped by a second trigger distinguishes stop from completion.
- Step mode driven from the pin shows the synchronizer latency. It also shows that the list does not advance on the timer, on a rising edge, or on the unselected software source.
- An empty list confirms that triggers are ignored.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  typedef struct packed {
    logic start;
    logic advance;
    logic stop;
  } seqCmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;
endpackage

// File: rtl/flseq_trig.sv
module flseq_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgHwTrig,
  input  logic trigPin,
  input  logic swTrig,
  output logic trigEvt
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinLast;
  logic trigFall;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= trigPin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) pinLast <= 1'b1;
    else       pinLast <= syncQ[SYNC_STAGES-1];
  end

  assign trigFall = pinLast & ~syncQ[SYNC_STAGES-1];
  assign trigEvt  = cfgHwTrig ? trigFall : swTrig;

  // R1: a falling edge gives exactly one event
  p_fall_once_r1: assert property (@(posedge clk) disable iff (!rstN)
    trigFall |=> !trigFall);
endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
  import flseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    trigEvt,
  input  logic    cfgStepMode,
  input  logic    numZero,
  input  logic    dwellDone,
  input  logic    cycleEnd,
  input  logic    finalCycle,
  output seqCmd_t cmd,
  output logic    listRunning,
  output logic    listDone
);
  seqState_t state, stateNext;
  logic doneNext;
  logic wantAdv;
  logic finish;

  always_comb begin
    cmd       = '0;
    stateNext = state;
    doneNext  = listDone;
    wantAdv   = 1'b0;
    finish    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (trigEvt && !numZero) begin
          cmd.start = 1'b1;
          stateNext = ST_RUN;
          doneNext  = 1'b0;
        end
      end
      default: begin
        if (cfgStepMode) begin
          wantAdv = trigEvt;
        end else if (trigEvt) begin
          cmd.stop  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          wantAdv = dwellDone;
        end
        if (wantAdv) begin
          if (cycleEnd && finalCycle) begin
            finish    = 1'b1;
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end else begin
            cmd.advance = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      listDone <= 1'b0;
    end else begin
      state    <= stateNext;
      listDone <= doneNext;
    end
  end

  assign listRunning = (state == ST_RUN);

  // R8: completion only follows the end of the final cycle
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(listRunning) && listDone) |-> ($past(cycleEnd) && $past(finalCycle)));
endmodule

// File: rtl/flseq_dp.sv
module flseq_dp
  import flseq_pkg::*;
#(
  parameter int IDX_W   = 24,
  parameter int DWELL_W = 32,
  parameter int CYC_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IDX_W-1:0]   cfgNumPoints,
  input  logic [DWELL_W-1:0] cfgDwell,
  input  logic [CYC_W-1:0]   cfgCycles,
  input  logic               cfgDirDown,
  input  logic               cfgBounce,
  input  seqCmd_t            cmd,
  input  logic               listRunning,
  output logic [IDX_W-1:0]   pointIdx,
  output logic               pointStrobe,
  output logic               dwellDone,
  output logic               cycleEnd,
  output logic               finalCycle
);
  logic [DWELL_W-1:0] dwellCnt, dwellLim;
  logic [CYC_W-1:0]   cycCnt;
  logic               returning;
  logic [IDX_W-1:0]   lastIdx, firstIdx, endIdx, fwdIdx, backIdx;
  logic               single;
  logic               atTurn;

  assign dwellLim  = (cfgDwell == '0) ? DWELL_W'(1) : cfgDwell;
  assign dwellDone = (dwellCnt >= dwellLim - DWELL_W'(1));

  assign lastIdx  = cfgNumPoints - IDX_W'(1);
  assign firstIdx = cfgDirDown ? lastIdx : '0;
  assign endIdx   = cfgDirDown ? '0 : lastIdx;
  assign fwdIdx   = cfgDirDown ? pointIdx - IDX_W'(1) : pointIdx + IDX_W'(1);
  assign backIdx  = cfgDirDown ? pointIdx + IDX_W'(1) : pointIdx - IDX_W'(1);
  assign single   = (cfgNumPoints == IDX_W'(1));

  assign cycleEnd = single
                  | (!cfgBounce && pointIdx == endIdx)
                  | (cfgBounce && returning && pointIdx == firstIdx);
  assign atTurn   = cfgBounce && !returning && pointIdx == endIdx;
  assign finalCycle = (cfgCycles != '0) && (cycCnt == cfgCycles - CYC_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dwellCnt <= '0;
    end else if (cmd.start || cmd.advance) begin
      dwellCnt <= '0;
    end else if (!dwellDone) begin
      dwellCnt <= dwellCnt + DWELL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pointIdx    <= '0;
      cycCnt      <= '0;
      returning   <= 1'b0;
      pointStrobe <= 1'b0;
    end else begin
      pointStrobe <= cmd.start | cmd.advance;
      if (cmd.start) begin
        pointIdx  <= firstIdx;
        cycCnt    <= '0;
        returning <= 1'b0;
      end else if (cmd.advance) begin
        if (cycleEnd) begin
          cycCnt    <= cycCnt + CYC_W'(1);
          returning <= 1'b0;
          pointIdx  <= (single || !cfgBounce) ? firstIdx : fwdIdx;
        end else if (atTurn) begin
          returning <= 1'b1;
          pointIdx  <= backIdx;
        end else if (returning) begin
          pointIdx  <= backIdx;
        end else begin
          pointIdx  <= fwdIdx;
        end
      end
    end
  end

  // R6: a running list stays inside the point range
  p_idx_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (listRunning && cfgNumPoints != '0) |-> (pointIdx < cfgNumPoints));

  // R9: the index only moves together with the strobe
  p_idx_moves_with_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pointIdx) |-> pointStrobe);
endmodule

// File: rtl/freq_list_seq.sv
module freq_list_seq
  import flseq_pkg::*;
#(
  parameter int IDX_W       = 24,
  parameter int DWELL_W     = 32,
  parameter int CYC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IDX_W-1:0]   cfgNumPoints,
  input  logic [DWELL_W-1:0] cfgDwell,
  input  logic [CYC_W-1:0]   cfgCycles,
  input  logic               cfgDirDown,
  input  logic               cfgBounce,
  input  logic               cfgHwTrig,
  input  logic               cfgStepMode,
  input  logic               trigPin,
  input  logic               swTrig,
  output logic [IDX_W-1:0]   pointIdx,
  output logic               pointStrobe,
  output logic               listRunning,
  output logic               listDone
);
  seqCmd_t cmd;
  logic trigEvt, dwellDone, cycleEnd, finalCycle;

  flseq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rstN(rstN), .cfgHwTrig(cfgHwTrig),
    .trigPin(trigPin), .swTrig(swTrig), .trigEvt(trigEvt)
  );

  flseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trigEvt(trigEvt), .cfgStepMode(cfgStepMode),
    .numZero(cfgNumPoints == '0), .dwellDone(dwellDone),
    .cycleEnd(cycleEnd), .finalCycle(finalCycle), .cmd(cmd),
    .listRunning(listRunning), .listDone(listDone)
  );

  flseq_dp #(.IDX_W(IDX_W), .DWELL_W(DWELL_W), .CYC_W(CYC_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgNumPoints(cfgNumPoints), .cfgDwell(cfgDwell),
    .cfgCycles(cfgCycles), .cfgDirDown(cfgDirDown), .cfgBounce(cfgBounce),
    .cmd(cmd), .listRunning(listRunning), .pointIdx(pointIdx),
    .pointStrobe(pointStrobe), .dwellDone(dwellDone),
    .cycleEnd(cycleEnd), .finalCycle(finalCycle)
  );

  // R2 / R9: starting presents the first point with a strobe
  p_start_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(listRunning) |-> pointStrobe);

  // R4: running and done never coexist
  p_run_done_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(listRunning && listDone));

  // R5: in step mode a new point always follows a trigger
  p_step_needs_trig_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pointStrobe && $past(cfgStepMode) && $past(listRunning)) |-> $past(trigEvt));

  // R10: an empty list never starts
  p_empty_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgNumPoints == '0) && !$past(listRunning)) |-> !listRunning);
endmodule

// File: tb/tb_freq_list_seq.sv
`timescale 1ns/1ps
module tb_freq_list_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] cfgNumPoints = '0;
  logic [31:0] cfgDwell = '0;
  logic [15:0] cfgCycles = '0;
  logic        cfgDirDown = 1'b0, cfgBounce = 1'b0, cfgHwTrig = 1'b0, cfgStepMode = 1'b0;
  logic        trigPin = 1'b1, swTrig = 1'b0;
  logic [23:0] pointIdx;
  logic        pointStrobe, listRunning, listDone;

  int total = 0, bad = 0, cyc = 0, nSeen = 0;
  int seen [0:63];
  int stamp[0:63];

  always #4 clk = ~clk;

  freq_list_seq dut (
    .clk(clk), .rstN(rstN), .cfgNumPoints(cfgNumPoints), .cfgDwell(cfgDwell),
    .cfgCycles(cfgCycles), .cfgDirDown(cfgDirDown), .cfgBounce(cfgBounce),
    .cfgHwTrig(cfgHwTrig), .cfgStepMode(cfgStepMode), .trigPin(trigPin),
    .swTrig(swTrig), .pointIdx(pointIdx), .pointStrobe(pointStrobe),
    .listRunning(listRunning), .listDone(listDone)
  );

  always @(negedge clk) begin
    cyc++;
    if (pointStrobe && nSeen < 64) begin
      seen[nSeen]  = int'(pointIdx);
      stamp[nSeen] = cyc;
      nSeen++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic swPulse();
    @(negedge clk) swTrig = 1'b1;
    @(negedge clk) swTrig = 1'b0;
  endtask

  task automatic waitDone(input int lim);
    for (int i = 0; i < lim && !listDone; i++) @(negedge clk);
  endtask

  task automatic pinFall();
    @(negedge clk) trigPin = 1'b0;
    repeat (6) @(negedge clk);
    trigPin = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic checkSeq(input string req, input int exp[], input int gap);
    chk(nSeen == exp.size(), {req, " count"}, nSeen, exp.size());
    for (int i = 0; i < exp.size() && i < nSeen; i++) begin
      chk(seen[i] == exp[i], {req, " index"}, seen[i], exp[i]);
      if (i > 0) chk(stamp[i] - stamp[i-1] == gap, "R3 spacing", stamp[i] - stamp[i-1], gap);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(pointIdx == 0 && !pointStrobe && !listRunning && !listDone, "R11 reset outputs",
        {pointIdx, pointStrobe, listRunning, listDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_wrapUp();
    cfgNumPoints = 4; cfgDwell = 3; cfgCycles = 2;
    cfgDirDown = 0; cfgBounce = 0; cfgHwTrig = 0; cfgStepMode = 0;
    nSeen = 0;
    swPulse();
    chk(pointStrobe && listRunning && pointIdx == 0, "R2 start at first point",
        {pointStrobe, listRunning, pointIdx}, 3 << 24);
    @(negedge clk);
    chk(!pointStrobe, "R9 strobe one cycle", pointStrobe, 0);
    waitDone(200);
    checkSeq("R6 wrap up", '{0,1,2,3,0,1,2,3}, 3);
    chk(listDone && !listRunning && pointIdx == 3, "R8 end after cycles",
        {listDone, listRunning, pointIdx}, (2 << 24) | 3);
  endtask

  task automatic t_bounceDown();
    cfgNumPoints = 4; cfgDwell = 0; cfgCycles = 1;
    cfgDirDown = 1; cfgBounce = 1; cfgStepMode = 0;
    nSeen = 0;
    swPulse();
    chk(!listDone, "R8 done cleared at start", listDone, 0);
    waitDone(200);
    checkSeq("R7 bounce down", '{3,2,1,0,1,2,3}, 1);
    chk(listDone && pointIdx == 3, "R8 bounce end", {listDone, pointIdx}, (1 << 24) | 3);
  endtask

  task automatic t_bounceUp();
    cfgNumPoints = 3; cfgDwell = 2; cfgCycles = 2;
    cfgDirDown = 0; cfgBounce = 1; cfgStepMode = 0;
    nSeen = 0;
    swPulse();
    waitDone(200);
    checkSeq("R7 bounce up two cycles", '{0,1,2,1,0,1,2,1,0}, 2);
  endtask

  task automatic t_stopRun();
    int held;
    cfgNumPoints = 2; cfgDwell = 2; cfgCycles = 0;
    cfgDirDown = 0; cfgBounce = 0; cfgStepMode = 0;
    swPulse();
    repeat (30) @(negedge clk);
    chk(listRunning && !listDone, "R8 zero cycles endless", {listRunning, listDone}, 2);
    swPulse();
    chk(!listRunning && !listDone, "R4 stop by trigger", {listRunning, listDone}, 0);
    held = int'(pointIdx);
    nSeen = 0;
    repeat (10) @(negedge clk);
    chk(nSeen == 0 && int'(pointIdx) == held, "R4 held after stop", nSeen, 0);
  endtask

  task automatic t_stepHw();
    cfgNumPoints = 3; cfgDwell = 1; cfgCycles = 1;
    cfgDirDown = 0; cfgBounce = 0; cfgHwTrig = 1; cfgStepMode = 1;
    nSeen = 0;
    @(negedge clk) trigPin = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(!pointStrobe, "R1 no early action", pointStrobe, 0);
    @(negedge clk);
    chk(pointStrobe && pointIdx == 0, "R1 acts after third edge", pointStrobe, 1);
    repeat (4) @(negedge clk);
    trigPin = 1'b1;
    repeat (12) @(negedge clk);
    chk(nSeen == 1, "R5 no advance on dwell or rising edge", nSeen, 1);
    swPulse();
    repeat (3) @(negedge clk);
    chk(nSeen == 1 && pointIdx == 0, "R1 software trigger ignored", nSeen, 1);
    pinFall();
    chk(pointIdx == 1 && nSeen == 2, "R5 one step per trigger", pointIdx, 1);
    pinFall();
    chk(pointIdx == 2 && nSeen == 3, "R5 second step", pointIdx, 2);
    pinFall();
    chk(listDone && !listRunning && pointIdx == 2 && nSeen == 3, "R8 step mode end",
        {listDone, listRunning, pointIdx}, (2 << 24) | 2);
    cfgHwTrig = 0; cfgStepMode = 0;
  endtask

  task automatic t_ignores();
    cfgNumPoints = 0; cfgDwell = 1; cfgCycles = 1;
    nSeen = 0;
    swPulse();
    repeat (3) @(negedge clk);
    chk(!listRunning && nSeen == 0, "R10 empty list ignores trigger", listRunning, 0);
    cfgNumPoints = 3;
    pinFall();
    chk(!listRunning && nSeen == 0, "R1 pin ignored in software mode", listRunning, 0);
  endtask

  task automatic t_single();
    cfgNumPoints = 1; cfgDwell = 2; cfgCycles = 3;
    cfgDirDown = 0; cfgBounce = 0; cfgStepMode = 0;
    nSeen = 0;
    swPulse();
    waitDone(100);
    checkSeq("R9 single point strobes", '{0,0,0}, 2);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    t_reset();
    t_wrapUp();
    t_bounceDown();
    t_bounceUp();
    t_stopRun();
    t_stepHw();
    t_ignores();
    t_single();
    finishRun();
  end
endmodule